// File: doc/BRIEF.md
# Seconds Counter with Alarm and Interrupts

This block keeps wall-clock time as a count of seconds and is reached through a plain 32-bit register bus. A prescaler outside the block delivers a single-cycle pulse once per second. On each pulse the counter advances by one. The block compares the count against an alarm value and raises two interrupt lines, one for every second and one for the alarm. It also holds two control bits that go to the oscillator and to the supply switch.

Software sets the time by writing a value into a holding register. The value waits there and can be read back. It is loaded into the counter only at the next one-second pulse, so a read of the current time stays consistent until that pulse arrives. Software can learn that the load has happened by clearing the seconds status bit after the write and waiting for the bit to be set again.

Each interrupt source has a status bit that is cleared by writing 1 to it. Each source also has a mask bit. Writing 1 to that bit at the enable offset clears the mask bit, and writing 1 to it at the disable offset sets the mask bit.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset the current time reads 0, the status reads 0, the mask reads 3 (both masked), the alarm reads 0xFFFFFFFF, the control register reads 0x01000000, and both interrupt lines are low.
- R2: A write to offset 0x00 stores the value in a holding register, which reads back at offset 0x04. The current time at offset 0x10 does not change until the next second pulse.
- R3: On a second pulse while a held value is waiting, the current time takes the held value and the waiting flag clears. The held value stays readable at 0x04.
- R4: On a second pulse with no held value waiting, the current time goes up by one, and 0xFFFFFFFF wraps to 0.
- R5: In cycles without a second pulse, the current time holds its value.
- R6: Status bit 0 at offset 0x20 is set on every second pulse.
- R7: Status bit 1 is set in every cycle in which the current time equals the alarm value at offset 0x18. A clear made while the two are still equal is undone at once.
- R8: Writing 1 to a status bit at 0x20 clears it, and bits written 0 keep their value. If a set event and a clear fall in the same cycle, the set wins.
- R9: Writing 1 to bit n at offset 0x28 clears mask bit n, and writing 1 to bit n at offset 0x2C sets it. Bits written 0 leave the mask unchanged. The mask reads at offset 0x24.
- R10: The seconds interrupt equals status bit 0 AND NOT mask bit 0. The alarm interrupt equals status bit 1 AND NOT mask bit 1.
- R11: The control register at offset 0x40 stores bit 31 (battery switch enable) and bit 24 (oscillator enable). These bits drive the matching outputs, and all other bits read 0.
- R12: Offsets that are not mapped read 0 and ignore writes. Writes to the read-only offsets 0x04 and 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse per second from the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |
| osc_enable | output | 1 | Oscillator enable (control bit 24) |
| batt_switch_en | output | 1 | Battery switch enable (control bit 31) |

## Verification
The hardest case to reach is the alarm status bit being set again while software is clearing it. The current time must sit exactly on the alarm value with no pulse arriving, and a clear must land during that window. The stimulus first loads a known time through the holding register. It then places the alarm one second ahead and issues a single pulse, and it clears the status while the two values still match. A second pulse moves the time past the alarm, and the clear is then shown to hold. A pulse and a status clear are also driven in the same cycle to show that the set wins.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
   localparam int BUS_W = 32;

   localparam logic [7:0] OFS_STAGE_WR  = 8'h00;
   localparam logic [7:0] OFS_STAGE_RD  = 8'h04;
   localparam logic [7:0] OFS_NOW       = 8'h10;
   localparam logic [7:0] OFS_ALARM     = 8'h18;
   localparam logic [7:0] OFS_STATUS    = 8'h20;
   localparam logic [7:0] OFS_MASK      = 8'h24;
   localparam logic [7:0] OFS_UNMASK    = 8'h28;
   localparam logic [7:0] OFS_MASKSET   = 8'h2C;
   localparam logic [7:0] OFS_CONTROL   = 8'h40;

   localparam int CTL_OSC_BIT  = 24;
   localparam int CTL_BATT_BIT = 31;

   localparam int NUM_SRC   = 2;
   localparam int SRC_SEC   = 0;
   localparam int SRC_ALARM = 1;
endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              stage_we,
   input  logic [TIME_W-1:0] stage_wdata,
   output logic [TIME_W-1:0] cur_time,
   output logic [TIME_W-1:0] stage_val,
   output logic              pending
);
   generate
      if (TIME_W < 2 || TIME_W > 32) begin : g_bad_w
         $error("rtc_time_counter: TIME_W out of range");
      end
   endgenerate

   localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_time  <= '0;
         stage_val <= '0;
         pending   <= 1'b0;
      end else begin
         if (tick) begin
            if (pending) cur_time <= stage_val;
            else         cur_time <= cur_time + ONE;
         end
         if (stage_we) begin
            stage_val <= stage_wdata;
            pending   <= 1'b1;
         end else if (tick) begin
            pending   <= 1'b0;
         end
      end
   end

   a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
      tick && pending |=> cur_time == $past(stage_val));
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !pending |=> cur_time == $past(cur_time) + ONE);
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cur_time));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
   parameter int TIME_W  = 32,
   parameter bit REG_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] cur_time,
   input  logic [TIME_W-1:0] alarm_val,
   output logic              match
);
   logic eq;
   assign eq = (cur_time == alarm_val);

   generate
      if (REG_CMP) begin : g_reg
         logic eq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) eq_q <= 1'b0;
            else        eq_q <= eq;
         end
         assign match = eq_q;
      end else begin : g_comb
         assign match = eq;
      end
   endgenerate
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_evt,
   input  logic            clr_we,
   input  logic            en_we,
   input  logic            dis_we,
   input  logic [NSRC-1:0] wbits,
   output logic [NSRC-1:0] status,
   output logic [NSRC-1:0] mask,
   output logic [NSRC-1:0] irq
);
   generate
      if (NSRC < 1) begin : g_bad_n
         $error("rtc_irq_unit: NSRC must be positive");
      end
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               status[i] <= 1'b0;
               mask[i]   <= 1'b1;
            end else begin
               if (set_evt[i])                status[i] <= 1'b1;
               else if (clr_we && wbits[i])   status[i] <= 1'b0;
               if (en_we && wbits[i])         mask[i]   <= 1'b0;
               else if (dis_we && wbits[i])   mask[i]   <= 1'b1;
            end
         end
         assign irq[i] = status[i] & ~mask[i];

         a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> status[i]);
         a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
            clr_we && wbits[i] && !set_evt[i] |=> !status[i]);
         a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
            clr_we && !wbits[i] && !set_evt[i] |=> status[i] == $past(status[i]));
         a_r9_unmask: assert property (@(posedge clk) disable iff (!rst_n)
            en_we && wbits[i] |=> !mask[i]);
         a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
            dis_we && wbits[i] |=> mask[i]);
      end
   endgenerate
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
   import rtc_core_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          TIME_W    = 32,
   parameter bit          REG_CMP   = 1'b0,
   parameter bit          OSC_RST   = 1'b1,
   parameter bit          BATT_RST  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_sec,
   output logic              irq_alarm,
   output logic              osc_enable,
   output logic              batt_switch_en
);
   generate
      if (ADDR_W < 7 || ADDR_W > 16) begin : g_bad_a
         $error("rtc_seconds_core: ADDR_W out of range");
      end
      if (TIME_W > BUS_W) begin : g_bad_t
         $error("rtc_seconds_core: TIME_W wider than bus");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_STW = ADDR_W'(OFS_STAGE_WR);
   localparam logic [ADDR_W-1:0] A_STR = ADDR_W'(OFS_STAGE_RD);
   localparam logic [ADDR_W-1:0] A_NOW = ADDR_W'(OFS_NOW);
   localparam logic [ADDR_W-1:0] A_ALM = ADDR_W'(OFS_ALARM);
   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_UNM = ADDR_W'(OFS_UNMASK);
   localparam logic [ADDR_W-1:0] A_MST = ADDR_W'(OFS_MASKSET);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CONTROL);

   logic              we_stage, we_alarm, we_clr, we_en, we_dis, we_ctl;
   logic [TIME_W-1:0] cur_time, stage_val, alarm_q;
   logic              pending, match;
   logic [NUM_SRC-1:0] set_evt, status, mask, irq;

   assign we_stage = bus_wr && (bus_addr == A_STW);
   assign we_alarm = bus_wr && (bus_addr == A_ALM);
   assign we_clr   = bus_wr && (bus_addr == A_STS);
   assign we_en    = bus_wr && (bus_addr == A_UNM);
   assign we_dis   = bus_wr && (bus_addr == A_MST);
   assign we_ctl   = bus_wr && (bus_addr == A_CTL);

   rtc_time_counter #(.TIME_W(TIME_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick),
      .stage_we(we_stage), .stage_wdata(bus_wdata[TIME_W-1:0]),
      .cur_time(cur_time), .stage_val(stage_val), .pending(pending)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q        <= '1;
         osc_enable     <= OSC_RST;
         batt_switch_en <= BATT_RST;
      end else begin
         if (we_alarm) alarm_q <= bus_wdata[TIME_W-1:0];
         if (we_ctl) begin
            osc_enable     <= bus_wdata[CTL_OSC_BIT];
            batt_switch_en <= bus_wdata[CTL_BATT_BIT];
         end
      end
   end

   rtc_alarm_cmp #(.TIME_W(TIME_W), .REG_CMP(REG_CMP)) u_cmp (
      .clk(clk), .rst_n(rst_n), .cur_time(cur_time),
      .alarm_val(alarm_q), .match(match)
   );

   always_comb begin
      set_evt            = '0;
      set_evt[SRC_SEC]   = sec_tick;
      set_evt[SRC_ALARM] = match;
   end

   rtc_irq_unit #(.NSRC(NUM_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_evt(set_evt),
      .clr_we(we_clr), .en_we(we_en), .dis_we(we_dis),
      .wbits(bus_wdata[NUM_SRC-1:0]),
      .status(status), .mask(mask), .irq(irq)
   );

   assign irq_sec   = irq[SRC_SEC];
   assign irq_alarm = irq[SRC_ALARM];

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_STR: bus_rdata[TIME_W-1:0]  = stage_val;
         A_NOW: bus_rdata[TIME_W-1:0]  = cur_time;
         A_ALM: bus_rdata[TIME_W-1:0]  = alarm_q;
         A_STS: bus_rdata[NUM_SRC-1:0] = status;
         A_MSK: bus_rdata[NUM_SRC-1:0] = mask;
         A_CTL: begin
            bus_rdata[CTL_OSC_BIT]  = osc_enable;
            bus_rdata[CTL_BATT_BIT] = batt_switch_en;
         end
         default: bus_rdata = '0;
      endcase
   end

   a_r2_stage: assert property (@(posedge clk) disable iff (!rst_n)
      we_stage |=> pending && stage_val == $past(bus_wdata[TIME_W-1:0]));
   a_r7_match: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> status[SRC_ALARM]);
   a_r11_ctl: assert property (@(posedge clk) disable iff (!rst_n)
      we_ctl |=> osc_enable == $past(bus_wdata[CTL_OSC_BIT])
                 && batt_switch_en == $past(bus_wdata[CTL_BATT_BIT]));
endmodule

// File: tb/sim_rtc_seconds_core.sv
`timescale 1ns/1ps
module sim_rtc_seconds_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_sec, irq_alarm, osc_enable, batt_switch_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtc_seconds_core u0 (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_sec(irq_sec), .irq_alarm(irq_alarm), .osc_enable(osc_enable),
      .batt_switch_en(batt_switch_en)
   );

   // vector: {op[1:0], req[3:0], addr[7:0], data[31:0]}; op 0 write, 1 read-check, 2 tick
   localparam int NV = 23;
   localparam logic [45:0] VEC [0:NV-1] = '{
      {2'd1, 4'd1,  8'h10, 32'h0000_0000},  // R1 time
      {2'd1, 4'd1,  8'h24, 32'h0000_0003},  // R1 mask
      {2'd1, 4'd1,  8'h20, 32'h0000_0000},  // R1 status
      {2'd1, 4'd1,  8'h18, 32'hFFFF_FFFF},  // R1 alarm
      {2'd1, 4'd1,  8'h40, 32'h0100_0000},  // R1 control
      {2'd0, 4'd2,  8'h00, 32'h0000_1000},  // R2 stage
      {2'd1, 4'd2,  8'h04, 32'h0000_1000},  // R2 readback
      {2'd1, 4'd2,  8'h10, 32'h0000_0000},  // R2 not yet applied
      {2'd2, 4'd3,  8'h00, 32'h0},          // tick
      {2'd1, 4'd3,  8'h10, 32'h0000_1000},  // R3 committed
      {2'd1, 4'd6,  8'h20, 32'h0000_0001},  // R6 seconds status
      {2'd2, 4'd4,  8'h00, 32'h0},          // tick
      {2'd1, 4'd4,  8'h10, 32'h0000_1001},  // R4 increment
      {2'd0, 4'd8,  8'h20, 32'h0000_0001},  // R8 clear
      {2'd1, 4'd8,  8'h20, 32'h0000_0000},  // R8 cleared
      {2'd0, 4'd11, 8'h40, 32'hFFFF_FFFF},  // R11 write all
      {2'd1, 4'd11, 8'h40, 32'h8100_0000},  // R11 only two bits
      {2'd0, 4'd12, 8'h14, 32'h0000_0055},  // R12 unmapped
      {2'd1, 4'd12, 8'h14, 32'h0000_0000},  // R12 reads zero
      {2'd0, 4'd12, 8'h04, 32'h0000_0077},  // R12 read-only write
      {2'd1, 4'd12, 8'h04, 32'h0000_1000},  // R12 unchanged
      {2'd0, 4'd9,  8'h28, 32'h0000_0001},  // R9 unmask bit0
      {2'd1, 4'd9,  8'h24, 32'h0000_0002}   // R9 mask read
   };

   task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL R%0d: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_check(input int req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic tick();
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, {30'd0, irq_alarm, irq_sec}, 32'd0); // R1 irqs low

      for (int i = 0; i < NV; i++) begin
         case (VEC[i][45:44])
            2'd0: wr(VEC[i][39:32], VEC[i][31:0]);
            2'd1: rd_check(int'(VEC[i][43:40]), VEC[i][39:32], VEC[i][31:0]);
            default: tick();
         endcase
      end
      check(11, {30'd0, batt_switch_en, osc_enable}, 32'd3); // R11 outputs

      // R10: seconds interrupt follows status and mask
      tick();                                   // time 0x1002
      check(10, {30'd0, irq_alarm, irq_sec}, 32'd1);
      wr(8'h2C, 32'h1);                         // mask again
      check(10, {31'd0, irq_sec}, 32'd0);
      rd_check(10, 8'h20, 32'h1);
      wr(8'h2C, 32'h0);                         // R9 zero bits no effect
      rd_check(9, 8'h24, 32'h3);
      wr(8'h20, 32'h1);

      // R5: no tick, time holds
      repeat (20) @(negedge clk);
      rd_check(5, 8'h10, 32'h1002);

      // R8: tick and clear in the same cycle, set wins
      bus_addr = 8'h20; bus_wdata = 32'h1; bus_wr = 1'b1; sec_tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; sec_tick = 1'b0;
      rd_check(8, 8'h20, 32'h1);                // time 0x1003
      wr(8'h20, 32'h1);

      // R7: alarm match and re-set while equal
      wr(8'h18, 32'h1004);
      rd_check(7, 8'h18, 32'h1004);
      wr(8'h28, 32'h2);
      tick();                                   // time 0x1004
      @(negedge clk);
      rd_check(7, 8'h20, 32'h3);
      check(10, {31'd0, irq_alarm}, 32'd1);
      wr(8'h20, 32'h2);
      rd_check(7, 8'h20, 32'h3);                // still equal, set again
      tick();                                   // time 0x1005
      wr(8'h20, 32'h3);
      rd_check(7, 8'h20, 32'h0);
      check(10, {31'd0, irq_alarm}, 32'd0);

      // R4: wrap
      wr(8'h00, 32'hFFFF_FFFF);
      tick();
      rd_check(3, 8'h10, 32'hFFFF_FFFF);
      tick();
      rd_check(4, 8'h10, 32'h0000_0000);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule